// File: doc/BRIEF.md
# CAN Transmit Mailbox Bank

This block holds the outgoing frames of a CAN controller in three transmit mailboxes that a host fills through a simple register bus. Each mailbox keeps an identifier word, a length word and two 32-bit payload words. When the host writes an identifier word with its request bit set, the mailbox becomes pending. From then on it is locked against host writes until the frame has been sent.

A downstream frame transmitter signals that it is idle with `tx_ready`. The bank then picks one pending mailbox and presents that mailbox's contents with `tx_valid` until the transmitter pulses `tx_done`. Completion clears the mailbox's request bit and sets a completion flag in a shared status word. The host clears each flag by writing 1 to it. The `irq` output is raised while the interrupt enable is set and any flag is set.

A control bit chooses how the next mailbox is picked. In request-order mode, pending mailboxes leave in the order in which they were requested. In identifier mode, the mailbox with the lowest identifier leaves first.

Top module: `can_txmb_bank`

## Requirements
- R1: After reset, every mailbox word, the control word and the status word read 0, and `tx_valid` and `irq` are 0.
- R2: Mailbox i occupies byte offsets 16*i to 16*i+15, holding the identifier word at +0, the length word at +4, payload word 0 at +8 and payload word 1 at +12. The length word keeps only the data length code in bits 3..0, and its other bits read as 0. The control word is at 0x30 and the status word is at 0x34. All words read back what was written.
- R3: In the identifier word, bit 0 is the request bit, bit 1 marks a remote frame and bit 2 selects the extended format. Writing the word with bit 0 set makes the mailbox pending. When `tx_ready` is seen high while the bank is idle and some mailbox is pending, `tx_valid` rises on the next cycle. The chosen mailbox then appears on `tx_slot`, `tx_id`, `tx_dlc`, `tx_data0` and `tx_data1`.
- R4: A `tx_done` pulse while `tx_valid` is high does three things on the following cycle. It clears the request bit of the mailbox being sent, sets that mailbox's completion flag in the status word (bit 8*i), and drops `tx_valid`.
- R5: Writing the status word with bit 8*i set clears flag i. Flags written with 0 are kept. A completion in the same cycle as a clear leaves the flag set.
- R6: Host writes to any word of a pending mailbox are ignored.
- R7: With control bit 0 set, pending mailboxes are sent in the order in which their requests were written.
- R8: With control bit 0 clear, the pending mailbox with the lowest key is sent first. For an extended identifier (bit 2 = 1) the key is bits 31..3. For a standard identifier the key is bits 31..21 followed by 18 zero bits. Equal keys go to the lower mailbox index.
- R9: `irq` equals control bit 1 ANDed with the OR of all completion flags.
- R10: While `tx_valid` is high and no `tx_done` arrives, `tx_valid` and `tx_slot` stay unchanged, even if new requests arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Write byte address |
| bus_wdata | input | DW | Write data |
| bus_rd_addr | input | AW | Read byte address |
| bus_rdata | output | DW | Read data, combinational |
| tx_ready | input | 1 | Transmitter idle and able to take a frame |
| tx_valid | output | 1 | A frame is presented to the transmitter |
| tx_slot | output | $clog2(NUM_MB) | Index of the mailbox being sent |
| tx_id | output | DW | Identifier word of the frame |
| tx_dlc | output | 4 | Data length code |
| tx_data0 | output | DW | Payload word 0 |
| tx_data1 | output | DW | Payload word 1 |
| tx_done | input | 1 | One-cycle completion pulse from the transmitter |
| irq | output | 1 | Mailbox-empty interrupt |

## Verification
The bench builds the block with its defaults: NUM_MB = 3, AW = 8 and DW = 32. These values place the completion flags at bits 0, 8 and 16 of one status word, so all three flag positions can be observed. They also give a 2-bit rank counter with one unused code, and the permutations of three requests exercise both selection modes. Because the bench holds `tx_ready` low while it loads the mailboxes, all three mailboxes compete in every vector. This brings within reach the equal-key tie between a standard and an extended identifier, and the hold of a running transfer against a new higher-priority request.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int KEY_W = 29;
  localparam int DLC_W = 4;

  localparam logic [1:0] W_ID  = 2'd0;
  localparam logic [1:0] W_LEN = 2'd1;
  localparam logic [1:0] W_D0  = 2'd2;
  localparam logic [1:0] W_D1  = 2'd3;

  // Priority key: extended ids use all 29 bits, standard ids are left-aligned.
  function automatic logic [KEY_W-1:0] prio_key(input logic [31:0] idw);
    if (idw[2]) return idw[31:3];
    return {idw[31:21], 18'b0};
  endfunction
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_word,
  input  logic [DW-1:0]    wr_data,
  input  logic             done,
  output logic [DW-1:0]    id_q,
  output logic [DLC_W-1:0] dlc_q,
  output logic [DW-1:0]    d0_q,
  output logic [DW-1:0]    d1_q,
  output logic             pending,
  output logic             req_new
);
  logic accept;

  assign pending = id_q[0];
  assign accept  = wr_en && !pending;
  assign req_new = accept && (wr_word == W_ID) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      dlc_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      if (done) id_q[0] <= 1'b0;
      if (accept) begin
        case (wr_word)
          W_ID:    id_q  <= wr_data;
          W_LEN:   dlc_q <= wr_data[DLC_W-1:0];
          W_D0:    d0_q  <= wr_data;
          default: d1_q  <= wr_data;
        endcase
      end
    end
  end

  AST_LOCKED_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pending) |=> ($stable(d0_q) && $stable(d1_q) && $stable(dlc_q) && $stable(id_q[DW-1:1]))); // R6
endmodule

// File: rtl/can_txmb_order.sv
module can_txmb_order #(
  parameter int N  = 3,
  parameter int RW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         pend,
  input  logic [N-1:0]         req_new,
  input  logic [N-1:0]         done_vec,
  output logic [N-1:0][RW-1:0] rank_q
);
  logic [RW-1:0] done_rank;
  logic [RW-1:0] live_cnt;
  logic          any_done;

  always_comb begin
    done_rank = '0;
    for (int i = 0; i < N; i++)
      if (done_vec[i]) done_rank = rank_q[i];
    live_cnt = RW'($countones(pend & ~done_vec));
    any_done = |done_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (req_new[i])
          rank_q[i] <= live_cnt;
        else if (pend[i] && !done_vec[i] && any_done && rank_q[i] > done_rank)
          rank_q[i] <= rank_q[i] - 1'b1;
      end
    end
  end

  for (genvar a = 0; a < N; a++) begin : g_ra
    for (genvar b = a + 1; b < N; b++) begin : g_rb
      AST_RANK_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[a] && pend[b]) |-> (rank_q[a] != rank_q[b])); // R7
    end
  end
endmodule

// File: rtl/can_txmb_sel.sv
module can_txmb_sel #(
  parameter int N  = 3,
  parameter int RW = 2,
  parameter int KW = 29,
  parameter int IW = 2
) (
  input  logic [N-1:0]         pend,
  input  logic                 by_order,
  input  logic [N-1:0][RW-1:0] rank,
  input  logic [N-1:0][KW-1:0] key,
  output logic                 any,
  output logic [IW-1:0]        win
);
  logic [RW-1:0] best_rank;
  logic [KW-1:0] best_key;

  always_comb begin
    any       = 1'b0;
    win       = '0;
    best_rank = '0;
    best_key  = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!any || (by_order ? (rank[i] < best_rank) : (key[i] < best_key)))) begin
        any       = 1'b1;
        win       = IW'(i);
        best_rank = rank[i];
        best_key  = key[i];
      end
    end
  end
endmodule

// File: rtl/can_txmb_bank.sv
module can_txmb_bank
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  input  logic [AW-1:0]             bus_rd_addr,
  output logic [DW-1:0]             bus_rdata,
  input  logic                      tx_ready,
  output logic                      tx_valid,
  output logic [$clog2(NUM_MB)-1:0] tx_slot,
  output logic [DW-1:0]             tx_id,
  output logic [3:0]                tx_dlc,
  output logic [DW-1:0]             tx_data0,
  output logic [DW-1:0]             tx_data1,
  input  logic                      tx_done,
  output logic                      irq
);
  localparam int IW       = $clog2(NUM_MB);
  localparam int RW       = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
  localparam int SW       = AW - 4;
  localparam int FLAG_SP  = 8;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_MB * 16);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_MB * 16 + 4);

  logic [DW-1:0]    id_w  [NUM_MB];
  logic [DLC_W-1:0] dlc_w [NUM_MB];
  logic [DW-1:0]    d0_w  [NUM_MB];
  logic [DW-1:0]    d1_w  [NUM_MB];
  logic [NUM_MB-1:0] pend_vec, req_vec, done_vec, mb_wr;
  logic [NUM_MB-1:0][KEY_W-1:0] key_w;
  logic [NUM_MB-1:0][RW-1:0]    rank_w;

  logic          by_order, irq_en;
  logic [NUM_MB-1:0] cmp_q;
  logic          busy;
  logic [IW-1:0] cur;
  logic          sel_any;
  logic [IW-1:0] sel_win;
  logic          ctrl_wr, stat_wr, mb_region;
  logic [IW-1:0] rsel;
  logic          unused_bits;

  assign unused_bits = &{1'b0, bus_addr[1:0], bus_rd_addr[1:0]};
  assign mb_region   = bus_addr < CTRL_ADDR;
  assign ctrl_wr     = bus_wr && (bus_addr == CTRL_ADDR);
  assign stat_wr     = bus_wr && (bus_addr == STAT_ADDR);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    assign mb_wr[i]    = bus_wr && mb_region && (bus_addr[AW-1:4] == SW'(i));
    assign done_vec[i] = busy && tx_done && (cur == IW'(i));
    assign key_w[i]    = prio_key(id_w[i]);

    can_txmb_slot #(.DW(DW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mb_wr[i]),
      .wr_word (bus_addr[3:2]),
      .wr_data (bus_wdata),
      .done    (done_vec[i]),
      .id_q    (id_w[i]),
      .dlc_q   (dlc_w[i]),
      .d0_q    (d0_w[i]),
      .d1_q    (d1_w[i]),
      .pending (pend_vec[i]),
      .req_new (req_vec[i])
    );
  end

  can_txmb_order #(.N(NUM_MB), .RW(RW)) u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_vec),
    .req_new  (req_vec),
    .done_vec (done_vec),
    .rank_q   (rank_w)
  );

  can_txmb_sel #(.N(NUM_MB), .RW(RW), .KW(KEY_W), .IW(IW)) u_sel (
    .pend     (pend_vec),
    .by_order (by_order),
    .rank     (rank_w),
    .key      (key_w),
    .any      (sel_any),
    .win      (sel_win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      by_order <= 1'b0;
      irq_en   <= 1'b0;
      cmp_q    <= '0;
      busy     <= 1'b0;
      cur      <= '0;
    end else begin
      if (ctrl_wr) begin
        by_order <= bus_wdata[0];
        irq_en   <= bus_wdata[1];
      end
      for (int i = 0; i < NUM_MB; i++) begin
        if (done_vec[i])                        cmp_q[i] <= 1'b1;
        else if (stat_wr && bus_wdata[i*FLAG_SP]) cmp_q[i] <= 1'b0;
      end
      if (busy && tx_done) begin
        busy <= 1'b0;
      end else if (!busy && tx_ready && sel_any) begin
        busy <= 1'b1;
        cur  <= sel_win;
      end
    end
  end

  assign tx_valid = busy;
  assign tx_slot  = cur;
  assign tx_id    = id_w[cur];
  assign tx_dlc   = dlc_w[cur];
  assign tx_data0 = d0_w[cur];
  assign tx_data1 = d1_w[cur];
  assign irq      = irq_en && (|cmp_q);

  assign rsel = IW'(bus_rd_addr[AW-1:4]);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd_addr < CTRL_ADDR) begin
      case (bus_rd_addr[3:2])
        W_ID:    bus_rdata = id_w[rsel];
        W_LEN:   bus_rdata = DW'(dlc_w[rsel]);
        W_D0:    bus_rdata = d0_w[rsel];
        default: bus_rdata = d1_w[rsel];
      endcase
    end else if (bus_rd_addr == CTRL_ADDR) begin
      bus_rdata[1:0] = {irq_en, by_order};
    end else if (bus_rd_addr == STAT_ADDR) begin
      for (int i = 0; i < NUM_MB; i++) bus_rdata[i*FLAG_SP] = cmp_q[i];
    end
  end

  AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pend_vec[cur]); // R10
  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done) |=> (busy && $stable(cur))); // R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_done) |=> (!busy && !pend_vec[$past(cur)] && cmp_q[$past(cur)])); // R4
  AST_ORDER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(by_order)) |-> (rank_w[cur] == '0)); // R7
endmodule

// File: tb/can_txmb_bank_tb.sv
module can_txmb_bank_tb;
  localparam logic [7:0] CTRL = 8'h30;
  localparam logic [7:0] STAT = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  bus_rd_addr = '0;
  logic [31:0] bus_rdata;
  logic        tx_ready = 1'b0;
  logic        tx_valid;
  logic [1:0]  tx_slot;
  logic [31:0] tx_id, tx_data0, tx_data1;
  logic [3:0]  tx_dlc;
  logic        tx_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  can_txmb_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_id(tx_id),
    .tx_dlc(tx_dlc), .tx_data0(tx_data0), .tx_data1(tx_data1),
    .tx_done(tx_done), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] w0, w1, w2;
    logic        mode;
    logic [5:0]  reqord;
    logic [5:0]  serve;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h24600000, 32'h20000000, 32'hFFE00000, 1'b0, {2'd0,2'd1,2'd2}, {2'd1,2'd0,2'd2}},
    '{32'h24600000, 32'h20000000, 32'hFFE00000, 1'b1, {2'd2,2'd0,2'd1}, {2'd2,2'd0,2'd1}},
    '{32'h0AA00000, 32'h0AA00000, 32'h0AA00000, 1'b0, {2'd2,2'd1,2'd0}, {2'd0,2'd1,2'd2}},
    '{32'hFFFFFFFC, 32'h00200000, 32'h00000084, 1'b0, {2'd0,2'd1,2'd2}, {2'd2,2'd1,2'd0}},
    '{32'h00000084, 32'h24600000, 32'hFFE00000, 1'b1, {2'd1,2'd2,2'd0}, {2'd1,2'd2,2'd0}},
    '{32'h00200004, 32'h00200000, 32'hFFE00000, 1'b0, {2'd1,2'd0,2'd2}, {2'd0,2'd1,2'd2}}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_ready();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w [3];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_valid == 1'b0, "R1 tx_valid", 32'(tx_valid), 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    rd(CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(STAT, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h00, v); chk(v == 0, "R1 mailbox0 id", v, 0);

    // R2 map and readback
    wr(8'h18, 32'hA5A5_0001); wr(8'h1C, 32'h5A5A_0002); wr(8'h14, 32'hFFFF_FFF7);
    rd(8'h18, v); chk(v == 32'hA5A5_0001, "R2 data0", v, 32'hA5A5_0001);
    rd(8'h1C, v); chk(v == 32'h5A5A_0002, "R2 data1", v, 32'h5A5A_0002);
    rd(8'h14, v); chk(v == 32'h7, "R2 dlc only", v, 32'h7);
    wr(CTRL, 32'h3); rd(CTRL, v); chk(v == 32'h3, "R2 ctrl", v, 32'h3);
    wr(CTRL, 32'h0);

    // R7 / R8 vector table
    for (int n = 0; n < NV; n++) begin
      w[0] = VECS[n].w0; w[1] = VECS[n].w1; w[2] = VECS[n].w2;
      wr(CTRL, {31'b0, VECS[n].mode});
      for (int k = 0; k < 3; k++) begin
        logic [1:0] s;
        s = VECS[n].reqord[5-2*k -: 2];
        wr(8'(s * 16 + 4), 32'(s + 1));
        wr(8'(s * 16), w[s] | 32'h1);
      end
      for (int k = 0; k < 3; k++) begin
        logic [1:0] e;
        e = VECS[n].serve[5-2*k -: 2];
        pulse_ready();
        chk(tx_valid && tx_slot == e, VECS[n].mode ? "R7 order slot" : "R8 priority slot",
            32'(tx_slot), 32'(e));
        chk(tx_id == (w[e] | 32'h1), "R3 tx_id", tx_id, w[e] | 32'h1);
        pulse_done();
        rd(STAT, v);
        chk(v[8*e] == 1'b1, "R4 flag set", v, 32'h1 << (8*e));
      end
      wr(STAT, 32'h0001_0101);
      rd(STAT, v); chk(v == 0, "R5 clear all", v, 0);
    end

    // R3 frame contents, R10 hold, R6 lock
    wr(CTRL, 32'h0);
    wr(8'h24, 32'h8); wr(8'h28, 32'h1111_2222); wr(8'h2C, 32'h3333_4444);
    wr(8'h20, 32'hFFE0_0001);
    pulse_ready();
    chk(tx_valid && tx_slot == 2, "R3 slot", 32'(tx_slot), 2);
    chk(tx_dlc == 4'h8, "R3 dlc", 32'(tx_dlc), 8);
    chk(tx_data0 == 32'h1111_2222, "R3 data0", tx_data0, 32'h1111_2222);
    chk(tx_data1 == 32'h3333_4444, "R3 data1", tx_data1, 32'h3333_4444);
    wr(8'h00, 32'h0020_0001);
    @(negedge clk); tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    tx_ready = 1'b0;
    chk(tx_valid && tx_slot == 2, "R10 hold slot", 32'(tx_slot), 2);
    wr(8'h28, 32'hDEAD_BEEF);
    rd(8'h28, v); chk(v == 32'h1111_2222, "R6 data locked", v, 32'h1111_2222);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk(v == 32'hFFE0_0001, "R6 id locked", v, 32'hFFE0_0001);
    pulse_done();
    chk(tx_valid == 1'b0, "R4 valid drops", 32'(tx_valid), 0);
    rd(8'h20, v); chk(v == 32'hFFE0_0000, "R4 request cleared", v, 32'hFFE0_0000);

    // R5 completion wins over same-cycle clear
    pulse_ready();
    chk(tx_valid && tx_slot == 0, "R3 next slot", 32'(tx_slot), 0);
    @(negedge clk);
    tx_done = 1'b1; bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 32'h1;
    @(negedge clk);
    tx_done = 1'b0; bus_wr = 1'b0;
    rd(STAT, v); chk(v == 32'h0001_0001, "R5 set wins", v, 32'h0001_0001);
    wr(STAT, 32'h0001_0000);
    rd(STAT, v); chk(v == 32'h1, "R5 partial clear", v, 32'h1);

    // R9 interrupt gating
    chk(irq == 1'b0, "R9 irq disabled", 32'(irq), 0);
    wr(CTRL, 32'h2);
    chk(irq == 1'b1, "R9 irq enabled", 32'(irq), 1);
    wr(STAT, 32'h1);
    chk(irq == 1'b0, "R9 irq no flags", 32'(irq), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule